// File: doc/BRIEF.md
# Per-Pin GPIO Control Register File

This block holds the configuration of thirteen general-purpose pins behind a byte-wide register bus. Every pin owns two byte registers: an output control byte that sets direction, drive style, pull resistor and driven level, and an input control byte that holds an edge-detect mode and reports the pin's present level. The output control bytes occupy one contiguous address window and the input control bytes the window directly above it.

The register contents drive the pad signals for every pin: output value, output enable, an open-drain flag, a pull enable and a two-bit pull select. The edge-detect mode of each pin is passed on unchanged to interrupt logic elsewhere. Each pad's input level goes through a two-flop synchronizer before software can read it.

Writes take effect on the rising clock edge where the write enable is high. Reads are combinational from the address, so read data shows the register contents as they stand in the current cycle.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: The output control byte of pin p (0 to 12) is at address 0x4E44+p. The input control byte of pin p is at address 0x4E51+p.
- R2: A write to an output control byte stores data bits 5:0. A read of that byte returns them with bits 7:6 as 0.
- R3: A write to an input control byte stores data bits 2:1 as the pin's detect mode. The mode appears on detectMode[2p+1:2p] and reads back in bits 2:1. Bits 7:3 read as 0.
- R4: Bit 0 of an input control byte is the pad level after a two-flop synchronizer. A change on padIn shows in the read data after the second rising edge and not after the first. Writing bit 0 has no effect.
- R5: With output control bit 5 = 1 (output) and bit 4 = 1 (push-pull), padOe is 1 and padOut equals bit 0.
- R6: With bit 5 = 1 and bit 4 = 0 (open drain), padOut is 0, padOpenDrain is 1, and padOe is 1 only when bit 0 is 0.
- R7: With bit 5 = 0 (input), padOe is 0 whatever the other bits hold.
- R8: pullEn[p] follows output control bit 3. pullSel[2p+1:2p] follows bits 2:1, encoded 00 = 2k down, 01 = 2k up, 10 = 50k down, 11 = 50k up.
- R9: Writes to addresses outside 0x4E44 to 0x4E5D change no register. Reads of those addresses return 0x00.
- R10: After reset, every output control byte and every detect mode is 0, so all pins are inputs with pulls off.
- R11: A read and a write to the same address in the same cycle return the value from before the write. The new value is readable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| padIn | input | 13 | Raw pad input levels |
| padOut | output | 13 | Pad output value |
| padOe | output | 13 | Pad output enable |
| padOpenDrain | output | 13 | 1 when the pin is in open-drain drive |
| pullEn | output | 13 | Pull resistor enable |
| pullSel | output | 26 | Pull select, two bits per pin |
| detectMode | output | 26 | Edge-detect mode, two bits per pin |

## Verification
A register write and a combinational read of the same address can fall in one cycle. The bench provokes this by holding a write to a pin's output byte on the bus and sampling busRdData before the clock edge, where it expects the old byte. After the edge it expects the new byte. A pad level change can also coincide with a read of the input byte. The bench samples after one edge and again after two, and judges the synchronizer delay from the point where bit 0 flips.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int PIN_FIELD_W = 8;
  localparam int BIT_DIR     = 5;
  localparam int BIT_PUSH    = 4;
  localparam int BIT_PULLEN  = 3;
  localparam int BIT_LEVEL   = 0;

  typedef struct packed {
    logic                   wrOut;
    logic                   wrIn;
    logic [PIN_FIELD_W-1:0] pin;
    logic [7:0]             data;
  } regStrobe_t;

  typedef struct packed {
    logic                   hitOut;
    logic                   hitIn;
    logic [PIN_FIELD_W-1:0] pin;
  } rdSel_t;
endpackage

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS = 13,
  parameter int ADDR_W   = 16,
  parameter int unsigned OUT_BASE = 32'h4E44,
  parameter int unsigned IN_BASE  = OUT_BASE + NUM_PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output regStrobe_t        strobe,
  output rdSel_t            rdSel
);
  localparam logic [ADDR_W-1:0] OUT_LO = ADDR_W'(OUT_BASE);
  localparam logic [ADDR_W-1:0] IN_LO  = ADDR_W'(IN_BASE);
  localparam logic [ADDR_W-1:0] PINS   = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] TOP_EX = ADDR_W'(IN_BASE + NUM_PINS);

  logic [ADDR_W-1:0] outOfs, inOfs;
  logic hitOut, hitIn;

  always_comb begin
    outOfs = busAddr - OUT_LO;
    inOfs  = busAddr - IN_LO;
    hitOut = (busAddr >= OUT_LO) && (outOfs < PINS);
    hitIn  = (busAddr >= IN_LO) && (inOfs < PINS);
  end

  always_comb begin
    rdSel.hitOut = hitOut;
    rdSel.hitIn  = hitIn;
    rdSel.pin    = hitOut ? PIN_FIELD_W'(outOfs) : PIN_FIELD_W'(inOfs);
    strobe.wrOut = busWrEn && hitOut;
    strobe.wrIn  = busWrEn && hitIn;
    strobe.pin   = rdSel.pin;
    strobe.data  = busWrData;
  end

  // R9: writes outside both windows raise no strobe
  assert_no_stray_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr < OUT_LO || busAddr >= TOP_EX)) |-> !(strobe.wrOut || strobe.wrIn));

  // R1: one window at a time
  assert_one_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOut, strobe.wrIn}));
endmodule

// File: rtl/gpio_pin_datapath.sv
module gpio_pin_datapath
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  rdSel_t                rdSel,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [7:0]            rdData,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padOpenDrain,
  output logic [NUM_PINS-1:0]   pullEn,
  output logic [2*NUM_PINS-1:0] pullSel,
  output logic [2*NUM_PINS-1:0] detectMode
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [5:0]          outCtl  [NUM_PINS];
  logic [1:0]          detMode [NUM_PINS];
  logic [NUM_PINS-1:0] syncA, syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    logic isOut, pushPull, level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outCtl[p]  <= '0;
        detMode[p] <= '0;
      end else begin
        if (strobe.wrOut && strobe.pin == PIN_FIELD_W'(p))
          outCtl[p] <= strobe.data[5:0];
        if (strobe.wrIn && strobe.pin == PIN_FIELD_W'(p))
          detMode[p] <= strobe.data[2:1];
      end
    end

    assign isOut    = outCtl[p][BIT_DIR];
    assign pushPull = outCtl[p][BIT_PUSH];
    assign level    = outCtl[p][BIT_LEVEL];

    assign padOe[p]        = isOut & (pushPull | ~level);
    assign padOut[p]       = pushPull & level;
    assign padOpenDrain[p] = ~pushPull;
    assign pullEn[p]       = outCtl[p][BIT_PULLEN];
    assign pullSel[2*p +: 2]    = outCtl[p][2:1];
    assign detectMode[2*p +: 2] = detMode[p];

    // R2: a strobe for this pin lands in its output byte
    assert_out_write_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrOut && strobe.pin == PIN_FIELD_W'(p)) |=> outCtl[p] == $past(strobe.data[5:0]));

    // R3: a strobe for this pin reaches the detect mode output
    assert_mode_write_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrIn && strobe.pin == PIN_FIELD_W'(p)) |=> detectMode[2*p +: 2] == $past(strobe.data[2:1]));

    // R6: open drain high level releases the pad
    assert_od_release_R6: assert property (@(posedge clk) disable iff (!rstN)
      (padOpenDrain[p] && level) |-> !padOe[p] && !padOut[p]);
  end

  logic [IDX_W-1:0] rdIdx;
  assign rdIdx = IDX_W'(rdSel.pin);

  always_comb begin
    rdData = 8'h00;
    if (rdSel.hitOut)
      rdData = {2'b00, outCtl[rdIdx]};
    else if (rdSel.hitIn)
      rdData = {5'b00000, detMode[rdIdx], syncB[rdIdx]};
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int NUM_PINS = 13,
  parameter int ADDR_W   = 16,
  parameter int unsigned OUT_BASE = 32'h4E44
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padOpenDrain,
  output logic [NUM_PINS-1:0]   pullEn,
  output logic [2*NUM_PINS-1:0] pullSel,
  output logic [2*NUM_PINS-1:0] detectMode
);
  localparam int unsigned IN_BASE = OUT_BASE + NUM_PINS;
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(OUT_BASE);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(IN_BASE + NUM_PINS - 1);

  regStrobe_t strobe;
  rdSel_t     rdSel;

  gpio_pin_decode #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE)
  ) uDecode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strobe(strobe), .rdSel(rdSel)
  );

  gpio_pin_datapath #(.NUM_PINS(NUM_PINS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .padIn(padIn),
    .rdData(busRdData), .padOut(padOut), .padOe(padOe),
    .padOpenDrain(padOpenDrain), .pullEn(pullEn), .pullSel(pullSel),
    .detectMode(detectMode)
  );

  // R9: unmapped addresses read as zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < LO_ADDR || busAddr > HI_ADDR) |-> busRdData == 8'h00);
endmodule

// File: tb/gpio_pin_ctrl_test.sv
module gpio_pin_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [12:0] padIn = '0;
  logic [12:0] padOut, padOe, padOpenDrain, pullEn;
  logic [25:0] pullSel, detectMode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_pin_ctrl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padOpenDrain(padOpenDrain),
    .pullEn(pullEn), .pullSel(pullSel), .detectMode(detectMode)
  );

  // address, write data, expected read back (padIn held at 0)
  localparam logic [31:0] VEC [8] = '{
    {16'h4E44, 8'hFF, 8'h3F},  // R2 R1 pin 0 output byte
    {16'h4E50, 8'h31, 8'h31},  // R1 pin 12 output byte
    {16'h4E51, 8'hFF, 8'h06},  // R3 pin 0 input byte, bit 0 ignored
    {16'h4E5D, 8'h04, 8'h04},  // R3 pin 12 input byte
    {16'h4E43, 8'hFF, 8'h00},  // R9 below window
    {16'h4E5E, 8'hFF, 8'h00},  // R9 above window
    {16'h4E4A, 8'h2E, 8'h2E},  // R6 pin 6 open drain low
    {16'h4E4B, 8'h0B, 8'h0B}   // R7 pin 7 input with pull
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R10 reset state
    busRead(16'h4E44, rd);  check("R10 out byte pin0", rd, 8'h00);
    busRead(16'h4E5D, rd);  check("R10 in byte pin12", rd, 8'h00);
    check("R10 padOe", padOe, 13'h0);
    check("R10 pullEn", pullEn, 13'h0);
    check("R10 detectMode", detectMode, 26'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      busWrite(VEC[i][31:16], VEC[i][15:8]);
      busRead(VEC[i][31:16], rd);
      check($sformatf("R1 R2 R3 R9 table entry %0d", i), rd, VEC[i][7:0]);
    end
    // R9 nothing near the window was touched by the stray writes
    busRead(16'h4E44, rd);  check("R9 pin0 kept", rd, 8'h3F);
    busRead(16'h4E5D, rd);  check("R9 pin12 mode kept", rd, 8'h04);

    // R5 push-pull outputs
    check("R5 pin0 oe/out", {padOe[0], padOut[0]}, 2'b11);
    check("R5 pin12 oe/out", {padOe[12], padOut[12], padOpenDrain[12]}, 3'b110);
    // R8 pulls
    check("R8 pin0 pull", {pullEn[0], pullSel[1:0]}, 3'b111);
    check("R8 pin12 pull", {pullEn[12], pullSel[25:24]}, 3'b000);
    check("R8 pin7 pull", {pullEn[7], pullSel[15:14]}, 3'b101);
    // R3 detect mode outputs
    check("R3 pin0 mode", detectMode[1:0], 2'b11);
    check("R3 pin12 mode", detectMode[25:24], 2'b10);
    // R6 open drain driving low, then released
    check("R6 pin6 low", {padOe[6], padOut[6], padOpenDrain[6]}, 3'b101);
    busWrite(16'h4E4A, 8'h2F);
    check("R6 pin6 released", {padOe[6], padOut[6], padOpenDrain[6]}, 3'b001);
    // R7 input direction never drives
    check("R7 pin7 oe", padOe[7], 1'b0);
    busWrite(16'h4E4B, 8'h11);
    check("R7 pin7 level set, dir in", padOe[7], 1'b0);

    // R4 synchronizer latency
    @(negedge clk);
    padIn[5] = 1'b1;
    busAddr = 16'h4E56;
    @(negedge clk);
    check("R4 after one edge", busRdData, 8'h00);
    @(negedge clk);
    check("R4 after two edges", busRdData, 8'h01);
    padIn[5] = 1'b0;
    busWrite(16'h4E56, 8'hF9);
    repeat (2) @(negedge clk);
    busRead(16'h4E56, rd);
    check("R4 bit0 write ignored", rd, 8'h00);

    // R11 read and write in the same cycle
    @(negedge clk);
    busAddr = 16'h4E45; busWrData = 8'h21; busWrEn = 1'b1;
    #1;
    check("R11 old value same cycle", busRdData, 8'h00);
    @(negedge clk);
    busWrEn = 1'b0;
    check("R11 new value next cycle", busRdData, 8'h21);

    // R10 reset again clears registers
    rstN = 1'b0;
    #1;
    busRead(16'h4E44, rd);
    check("R10 reset clears", rd, 8'h00);
    check("R10 reset oe", padOe, 13'h0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule